// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a successive approximation converter. When it sees a start pulse, it runs a binary search over an N-bit code. N is a parameter with a default of 10. In each cycle it drives a trial code to an external DAC and takes back one comparator bit. That bit says whether the DAC level lies above the sampled input. The block uses it to keep or clear the bit under test, then moves one position toward the LSB.

After the LSB has been decided, the block places the finished code on a result bus and raises a one-cycle end-of-conversion strobe. A busy flag covers the whole search. A start pulse that arrives during a search has no effect. The sample-and-hold, the DAC and the comparator are outside the block.

Top module: `sar_ctrl`

## Requirements
- R1: A synchronous active-high reset brings `busy`, `eoc`, `dac_code` and `data_out` to zero.
- R2: A `start` seen high while idle makes `busy` rise on the next cycle, with `dac_code` carrying only its MSB set.
- R3: On each busy cycle the block samples `comp_in` at the clock edge. If `comp_in` is 1 (DAC above input), the bit under test is cleared; if it is 0, the bit stays 1. On the same edge the next lower bit is set to 1.
- R4: Equality counts as not above, so the bit is kept. An input equal to the reference gives the all-ones code.
- R5: A conversion takes N busy cycles. `eoc` is high for exactly one cycle: the cycle after bit 0 is decided. `busy` falls in that same cycle.
- R6: With an ideal DAC (level = code × Vref / 2^N), `data_out` equals floor(Vin × 2^N / Vref), clamped to 2^N − 1. `dac_code` then shows the same final code.
- R7: `data_out` keeps the last finished result and changes only in a cycle where `eoc` is high. It does not follow the trial codes.
- R8: `start` while `busy` is ignored. The running search keeps its timing and its result, and no new conversion follows it.
- R9: In busy cycle k (k = 0 at the first busy cycle), `dac_code` has bit N−1−k set and all lower bits clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a conversion |
| comp_in | input | 1 | Comparator result, 1 when the DAC level is above the input |
| busy | output | 1 | High while a search is running |
| dac_code | output | N | Trial code driven to the DAC |
| data_out | output | N | Last finished conversion result |
| eoc | output | 1 | One-cycle end-of-conversion strobe |

## Verification
The assertions check the per-cycle shape of the search on every cycle:
- one new trial bit per busy cycle with zeros below it;
- the decided bit matching the inverted previous comparator value;
- the fixed N-cycle length with a single `eoc` pulse;
- the result bus staying still outside `eoc`;
- start pulses during a search being ignored.

Whether each final code is the correct quantisation of an analog level can only be shown by the bench's sweep against its ideal DAC. That sweep runs through every step level, both sides of each step and full scale. The same holds for the equality rule at exact step boundaries and for the absence of a queued conversion after a start pulse that arrived while busy.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // Controller phase: waiting for a start, or walking the bits
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } sar_state_e;

endpackage

// File: rtl/sar_ptr.sv
// Bit-position pointer: loads the MSB index, steps down once per decision
module sar_ptr #(
    parameter int N  = 10,
    parameter int PW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    output logic [PW-1:0] ptr,
    output logic          last
);

    localparam logic [PW-1:0] TOP_IDX = PW'(N - 1);

    logic [PW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load) begin
            ptr_d = TOP_IDX;
        end else if (step && (ptr_q != '0)) begin
            ptr_d = ptr_q - PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr  = ptr_q;
    assign last = (ptr_q == '0);

endmodule

// File: rtl/sar_trial_reg.sv
// Trial code register: applies keep/clear on the bit under test and arms the next one
module sar_trial_reg #(
    parameter int N  = 10,
    parameter int PW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          decide,
    input  logic [PW-1:0] ptr,
    input  logic          comp_in,
    output logic [N-1:0]  code,
    output logic [N-1:0]  code_next
);

    localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

    logic [N-1:0] code_d, code_q;
    logic [N-1:0] decided;

    // One slice per bit: the tested bit takes the inverted comparator, the
    // bit just below it becomes the next trial, the rest hold.
    for (genvar gi = 0; gi < N; gi++) begin : g_bit
        always_comb begin
            if (int'(ptr) == gi) begin
                decided[gi] = ~comp_in;
            end else if (int'(ptr) == gi + 1) begin
                decided[gi] = 1'b1;
            end else begin
                decided[gi] = code_q[gi];
            end
        end
    end

    always_comb begin
        code_d = code_q;
        if (load) begin
            code_d = MSB_ONLY;
        end else if (decide) begin
            code_d = decided;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

    assign code      = code_q;
    assign code_next = code_d;

endmodule

// File: rtl/sar_ctrl.sv
// Successive approximation conversion controller (top)
module sar_ctrl #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         comp_in,
    output logic         busy,
    output logic [N-1:0] dac_code,
    output logic [N-1:0] data_out,
    output logic         eoc
);

    import sar_pkg::*;

    localparam int PW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        sar_state_e   state;
        logic         busy;
        logic         eoc;
        logic [N-1:0] result;
    } ctrl_t;

    ctrl_t d, q;

    logic          load;
    logic          decide;
    logic [PW-1:0] ptr;
    logic          last;
    logic [N-1:0]  code_q;
    logic [N-1:0]  code_d;

    sar_ptr #(.N(N), .PW(PW)) u_ptr (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .step (decide),
        .ptr  (ptr),
        .last (last)
    );

    sar_trial_reg #(.N(N), .PW(PW)) u_trial (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .decide    (decide),
        .ptr       (ptr),
        .comp_in   (comp_in),
        .code      (code_q),
        .code_next (code_d)
    );

    always_comb begin
        d      = q;
        d.eoc  = 1'b0;
        load   = 1'b0;
        decide = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.state = ST_CONV;
                    d.busy  = 1'b1;
                    load    = 1'b1;
                end
            end
            ST_CONV: begin
                decide = 1'b1;
                if (last) begin
                    d.state  = ST_IDLE;
                    d.busy   = 1'b0;
                    d.eoc    = 1'b1;
                    d.result = code_d;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{state: ST_IDLE, busy: 1'b0, eoc: 1'b0, result: '0};
        end else begin
            q <= d;
        end
    end

    assign busy     = q.busy;
    assign eoc      = q.eoc;
    assign data_out = q.result;
    assign dac_code = code_q;

endmodule

// File: rtl/sar_ctrl_chk.sv
// Property checker for sar_ctrl, attached through bind
module sar_ctrl_chk #(
    parameter int N = 10
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         comp_in,
    input logic         busy,
    input logic [N-1:0] dac_code,
    input logic [N-1:0] data_out,
    input logic         eoc
);

    localparam int CW = $clog2(N + 1);
    localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

    logic [CW-1:0] step_q;
    logic          ok_q;
    logic          shape_ok;
    logic          prev_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
            ok_q   <= 1'b0;
        end else begin
            ok_q   <= 1'b1;
            step_q <= busy ? step_q + CW'(1) : '0;
        end
    end

    always_comb begin
        shape_ok = 1'b0;
        prev_bit = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (int'(step_q) == N - 1 - i) begin
                shape_ok = dac_code[i];
                for (int j = 0; j < i; j++) begin
                    if (dac_code[j]) shape_ok = 1'b0;
                end
            end
            if (int'(step_q) == N - i) begin
                prev_bit = dac_code[i];
            end
        end
    end

    // R2
    a_r2_start_loads_msb: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && dac_code == MSB_ONLY));

    // R9
    a_r9_trial_shape: assert property (@(posedge clk) disable iff (rst)
        busy |-> shape_ok);

    // R3
    a_r3_bit_follows_comp: assert property (@(posedge clk) disable iff (rst)
        (ok_q && busy && step_q != '0) |-> (prev_bit == !$past(comp_in)));

    // R3
    a_r3_lsb_follows_comp: assert property (@(posedge clk) disable iff (rst)
        (ok_q && eoc) |-> (data_out[0] == !$past(comp_in)));

    // R5
    a_r5_length: assert property (@(posedge clk) disable iff (rst)
        (busy && int'(step_q) == N - 1) |=> (eoc && !busy));

    // R5
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        eoc |=> !eoc);

    // R6
    a_r6_result_matches_code: assert property (@(posedge clk) disable iff (rst)
        eoc |-> (data_out == dac_code));

    // R7
    a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
        (ok_q && !eoc) |-> $stable(data_out));

    // R8
    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && int'(step_q) != N - 1) |=> (busy && !eoc));

endmodule

bind sar_ctrl sar_ctrl_chk #(.N(N)) u_sar_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .comp_in  (comp_in),
    .busy     (busy),
    .dac_code (dac_code),
    .data_out (data_out),
    .eoc      (eoc)
);

// File: tb/sar_ctrl_bench.sv
module sar_ctrl_bench;

    localparam int N     = 6;
    localparam int SCALE = 4;               // input units per LSB
    localparam int VREF  = SCALE * (1 << N);
    localparam int MAXC  = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         comp_in;
    logic         busy;
    logic [N-1:0] dac_code;
    logic [N-1:0] data_out;
    logic         eoc;
    int           vin = 0;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // Ideal DAC and comparator: high when code*Vref/2^N is above the input
    assign comp_in = ((int'(dac_code) * SCALE) > vin);

    sar_ctrl #(.N(N)) u_sar_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .comp_in  (comp_in),
        .busy     (busy),
        .dac_code (dac_code),
        .data_out (data_out),
        .eoc      (eoc)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (vin %0d, t %0t)", req, act, expv, vin, $time);
        end
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            summary();
        end
    end

    // One full conversion; poke pulses start during the search
    task automatic convert(input int v, input bit poke);
        int expc;
        logic [N-1:0] prev;
        expc = v / SCALE;
        if (expc > MAXC) expc = MAXC;
        prev  = data_out;
        vin   = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int p;
            int trial;
            p     = N - k;
            trial = (expc & ~((1 << (p + 1)) - 1)) | (1 << p);
            if (k == 1) check(busy == 1'b1, "R2 busy", busy, 1);
            check(int'(dac_code) == trial, "R3/R9 trial code", dac_code, trial);
            check(data_out == prev, "R7 hold during search", data_out, prev);
            check(eoc == 1'b0, "R5 no early eoc", eoc, 0);
            if (poke && k == 3) start = 1'b1;
            if (poke && k == 4) start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        check(eoc == 1'b1, "R5 eoc after bit 0", eoc, 1);
        check(busy == 1'b0, "R5 busy falls", busy, 0);
        if (v >= VREF) check(int'(data_out) == MAXC, "R4 full scale all ones", data_out, MAXC);
        check(int'(data_out) == expc, "R6 result", data_out, expc);
        check(int'(dac_code) == expc, "R6 final code on dac", dac_code, expc);
        @(negedge clk);
        check(eoc == 1'b0, "R5 single eoc pulse", eoc, 0);
        check(int'(data_out) == expc, "R7 result held", data_out, expc);
        if (poke) check(busy == 1'b0, "R8 no queued start", busy, 0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(eoc == 1'b0, "R1 eoc", eoc, 0);
        check(dac_code == '0, "R1 dac_code", dac_code, 0);
        check(data_out == '0, "R1 data_out", data_out, 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1 stays idle", busy, 0);

        // R4: exact full scale and exact step boundaries first
        convert(VREF, 1'b0);
        convert(SCALE * 37, 1'b0);
        convert(SCALE * 37 - 1, 1'b0);

        // R6: sweep every input level across the range, some with R8 pokes
        for (int v = 0; v <= VREF; v++) begin
            convert(v, (v % 7) == 3);
        end

        // Above full scale clamps to all ones
        convert(VREF + 9, 1'b1);

        // R7: long idle keeps the result
        repeat (5) @(negedge clk);
        check(int'(data_out) == MAXC, "R7 idle hold", data_out, MAXC);
        check(busy == 1'b0, "R8 idle", busy, 0);

        summary();
    end

endmodule